// File: doc/BRIEF.md
# Multi-Channel Push-Button Debouncer with Press Counters

This block takes a bus of raw mechanical push-button inputs into a fast synchronous design and turns each one into a clean, trustworthy signal. Every raw input is treated purely as data. It passes through a two-flop synchronizer into the system clock domain and is never used as a clock. A single prescaler, shared by all channels, divides the system clock down to a slow tick of about one millisecond. Each channel then runs a small stability filter that counts those ticks.

A channel changes its accepted (debounced) level only after the synchronized input has disagreed with that level for STABLE_TICKS consecutive ticks. Any cycle in which the input agrees with the accepted level restarts the count. Contact bounce is therefore rejected on both closing and opening. Deliberate presses, which are far slower than bounce, still get through.

When the accepted level of a channel rises, the channel emits a pulse one system-clock cycle wide. That pulse is the count enable of a small wrapping counter for the same channel, so each physical press adds exactly one to it.

Top module: `btn_debounce_counter`

## Requirements
- R1: The shared timebase produces one tick every TICK_DIV system clock cycles. After a clean input transition that then holds steady, the channel's level output follows it no sooner than (STABLE_TICKS-1)*TICK_DIV+2 and no later than STABLE_TICKS*TICK_DIV+3 rising clock edges after the input changes.
- R2: If the synchronized input differs from the accepted level for a run of at most (STABLE_TICKS-1)*TICK_DIV cycles and then agrees again, the level output does not change. A level change happens only on a timebase tick.
- R3: The filter applies to releases as well: bounce while opening never produces a premature release, and a steady release returns the level to 0 (released).
- R4: Each 0-to-1 change of a channel's level output produces a press pulse exactly one cycle wide, asserted in the same cycle the level becomes 1. A 1-to-0 change produces no pulse.
- R5: A channel's count output (CNT_W bits, channel k at bits k*CNT_W upward) increases by one in the cycle after that channel's press pulse, holds otherwise, and wraps from 2^CNT_W-1 to 0.
- R6: Channels are independent: activity on one button never changes another channel's level, pulse or count.
- R7: While rst_n is low, every level output reads 0, every press pulse reads 0 and every count reads 0. After reset the prescaler restarts, and R1 timing holds again.
- R8: Every deliberate press is counted, including a press that begins and ends with bounce bursts, when the press and the gap before the next one each hold steady for longer than STABLE_TICKS*TICK_DIV+3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_raw_i | input | N_BTN | Raw, unsynchronized button levels, 1 = pressed |
| btn_level_o | output | N_BTN | Debounced level per button, 1 = pressed |
| btn_press_o | output | N_BTN | One-cycle pulse per accepted press |
| btn_count_o | output | N_BTN*CNT_W | Packed press counters, channel k at bits [k*CNT_W +: CNT_W] |

## Verification
A stuck or miscounting stability counter shows up at the level outputs. The level either changes during a bounce burst that should have been rejected, or it moves outside the R1 latency window after a clean edge. Either way the fault is visible within about STABLE_TICKS*TICK_DIV cycles. A wrong edge register shows up on the press outputs as a missing pulse, a two-cycle pulse or a pulse on release, and the count output then differs from the number of deliberate presses one cycle later. A prescaler fault changes the acceptance latency of every channel at the same time, which the bench measures directly at the ports.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  typedef enum logic {
    LVL_RELEASED = 1'b0,
    LVL_PRESSED  = 1'b1
  } dbc_level_e;

  function automatic dbc_level_e dbc_flip(input dbc_level_e lvl);
    return (lvl == LVL_RELEASED) ? LVL_PRESSED : LVL_RELEASED;
  endfunction

endpackage

// File: rtl/dbc_rst_sync.sv
module dbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbc_tick_gen.sv
module dbc_tick_gen #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/dbc_filter.sv
module dbc_filter
  import dbc_pkg::*;
#(
  parameter int STABLE_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sample_i,
  output logic level_o,
  output logic press_o
);

  localparam int SW = $clog2(STABLE_TICKS + 1);
  localparam logic [SW-1:0] STAB_LAST = SW'(STABLE_TICKS - 1);

  dbc_level_e    level_q, level_d;
  logic [SW-1:0] stab_q, stab_d;
  logic          press_q, press_d;
  logic          differs;

  assign differs = (sample_i != logic'(level_q));

  always_comb begin
    level_d = level_q;
    stab_d  = stab_q;
    if (!differs) begin
      stab_d = '0;
    end else if (tick_i) begin
      if (stab_q == STAB_LAST) begin
        level_d = dbc_flip(level_q);
        stab_d  = '0;
      end else begin
        stab_d = stab_q + 1'b1;
      end
    end
    press_d = (level_d == LVL_PRESSED) && (level_q == LVL_RELEASED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_RELEASED;
      stab_q  <= '0;
      press_q <= 1'b0;
    end else begin
      level_q <= level_d;
      stab_q  <= stab_d;
      press_q <= press_d;
    end
  end

  assign level_o = logic'(level_q);
  assign press_o = press_q;

endmodule

// File: rtl/dbc_event_ctr.sv
module dbc_event_ctr #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/btn_debounce_counter.sv
module btn_debounce_counter #(
  parameter int N_BTN        = 4,
  parameter int TICK_DIV     = 100000,
  parameter int STABLE_TICKS = 20,
  parameter int CNT_W        = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_BTN-1:0]       btn_raw_i,
  output logic [N_BTN-1:0]       btn_level_o,
  output logic [N_BTN-1:0]       btn_press_o,
  output logic [N_BTN*CNT_W-1:0] btn_count_o
);

  logic             rst_core_n;
  logic             tick;
  logic [N_BTN-1:0] sampled;

  dbc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  dbc_sync #(.WIDTH(N_BTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (btn_raw_i),
    .sync_o  (sampled)
  );

  dbc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_o (tick)
  );

  for (genvar i = 0; i < N_BTN; i++) begin : g_chan
    dbc_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filter (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick_i   (tick),
      .sample_i (sampled[i]),
      .level_o  (btn_level_o[i]),
      .press_o  (btn_press_o[i])
    );

    dbc_event_ctr #(.WIDTH(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .en_i    (btn_press_o[i]),
      .count_o (btn_count_o[i*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
  parameter int N_BTN    = 4,
  parameter int TICK_DIV = 100000,
  parameter int CNT_W    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [N_BTN-1:0]       level,
  input logic [N_BTN-1:0]       press,
  input logic [N_BTN*CNT_W-1:0] count
);

  localparam int GW = $clog2(TICK_DIV + 1);
  localparam logic [GW-1:0] GAP_EXP = GW'(TICK_DIV - 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(TICK_DIV);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (gap_q == GAP_EXP)); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst_n) |=> (level == '0 && press == '0 && count == '0)); // R7

  for (genvar i = 0; i < N_BTN; i++) begin : g_ch
    AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (level[i] != $past(level[i])) |-> $past(tick)); // R2

    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      press[i] |=> !press[i]); // R4

    AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      press[i] |-> (level[i] && !$past(level[i]))); // R4

    AST_NO_PRESS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!level[i]) |-> !press[i]); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      press[i] |=> (count[i*CNT_W +: CNT_W] ==
                    CNT_W'($past(count[i*CNT_W +: CNT_W]) + 1'b1))); // R5

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!press[i]) |=> $stable(count[i*CNT_W +: CNT_W])); // R5
  end

endmodule

bind btn_debounce_counter dbc_checker #(
  .N_BTN    (N_BTN),
  .TICK_DIV (TICK_DIV),
  .CNT_W    (CNT_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .tick  (tick),
  .level (btn_level_o),
  .press (btn_press_o),
  .count (btn_count_o)
);

// File: tb/btn_debounce_counter_tb.sv
module btn_debounce_counter_tb;

  localparam int N   = 4;
  localparam int DIV = 8;
  localparam int ST  = 4;
  localparam int CW  = 4;
  localparam int MAX_RUN = (ST - 1) * DIV;
  localparam int SEG_MAX = MAX_RUN / 2;
  localparam int HOLD    = ST * DIV + 20;
  localparam int LAT_MIN = (ST - 1) * DIV + 2;
  localparam int LAT_MAX = ST * DIV + 3;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    raw;
  logic [N-1:0]    level;
  logic [N-1:0]    press;
  logic [N*CW-1:0] count;

  int checks;
  int errors;
  bit done;
  int exp_press [N];
  int pulse_cnt [N];
  int wide_cnt;
  logic [N-1:0] prev_press;

  btn_debounce_counter #(
    .N_BTN(N), .TICK_DIV(DIV), .STABLE_TICKS(ST), .CNT_W(CW), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_raw_i(raw),
    .btn_level_o(level), .btn_press_o(press), .btn_count_o(count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pulse monitor: counts pulses and flags pulses wider than one cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pulse_cnt[i] = 0;
      wide_cnt   = 0;
      prev_press = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (press[i]) begin
          pulse_cnt[i]++;
          if (prev_press[i]) wide_cnt++;
        end
      end
      prev_press = press;
    end
  end

  function automatic logic [CW-1:0] cnt_of(input int ch);
    return count[ch*CW +: CW];
  endfunction

  function automatic logic [CW-1:0] exp_cnt(input int n);
    return CW'(n % (1 << CW));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(4);
  endtask

  // alternating short runs, each below the acceptance window, ending at 'fin'
  task automatic bounce(input int ch, input bit fin);
    int n;
    n = 2 + int'($urandom_range(4, 0));
    for (int k = 0; k < n; k++) begin
      raw[ch] = ~fin;
      step(int'($urandom_range(SEG_MAX, 1)));
      raw[ch] = fin;
      step(int'($urandom_range(SEG_MAX, 1)));
    end
    raw[ch] = fin;
  endtask

  task automatic press_cycle(input int ch);
    bounce(ch, 1'b1);
    step(HOLD);
    exp_press[ch]++;
    bounce(ch, 1'b0);
    step(HOLD);
  endtask

  task automatic glitch(input int ch);
    int n;
    n = 1 + int'($urandom_range(3, 0));
    for (int k = 0; k < n; k++) begin
      raw[ch] = 1'b1;
      step(int'($urandom_range(SEG_MAX, 1)));
      raw[ch] = 1'b0;
      step(int'($urandom_range(SEG_MAX, 1)));
    end
    step(HOLD);
  endtask

  task automatic session(input int ch);
    int ops;
    ops = 4 + int'($urandom_range(4, 0));
    for (int k = 0; k < ops; k++) begin
      if ($urandom_range(3, 0) == 0) glitch(ch);
      else press_cycle(ch);
    end
  endtask

  task automatic measure(input int ch, input bit val, output int lat);
    lat = 0;
    raw[ch] = val;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      #1;
      if (level[ch] == val) break;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    int p0;
    void'($urandom(32'd1234));
    checks = 0;
    errors = 0;
    done   = 1'b0;
    raw    = '0;
    rst_n  = 1'b0;
    for (int i = 0; i < N; i++) exp_press[i] = 0;
    step(3);
    // R7: state while reset is held
    check(level == '0, "R7", "level in reset", int'(level), 0);
    check(press == '0, "R7", "press in reset", int'(press), 0);
    check(count == '0, "R7", "count in reset", int'(count), 0);
    rst_n = 1'b1;
    step(6);

    // R1: clean press latency on channel 0
    measure(0, 1'b1, lat);
    check(lat >= LAT_MIN && lat <= LAT_MAX, "R1", "press latency", lat, LAT_MIN);
    step(2);
    check(cnt_of(0) == 1, "R5", "count after one press", int'(cnt_of(0)), 1);
    check(pulse_cnt[0] == 1, "R4", "one pulse per press", pulse_cnt[0], 1);
    // R3: clean release latency, no pulse on release
    measure(0, 1'b0, lat);
    check(lat >= LAT_MIN && lat <= LAT_MAX, "R3", "release latency", lat, LAT_MIN);
    step(HOLD);
    check(pulse_cnt[0] == 1, "R4", "no pulse on release", pulse_cnt[0], 1);
    exp_press[0] = 1;

    // R2: a run of exactly the longest rejected length on channel 1
    raw[1] = 1'b1;
    step(MAX_RUN);
    raw[1] = 1'b0;
    step(HOLD);
    check(level[1] == 1'b0, "R2", "run below window ignored", int'(level[1]), 0);
    check(cnt_of(1) == 0, "R2", "count after rejected run", int'(cnt_of(1)), 0);

    // R6 R8: concurrent random sessions with bounce and glitches
    fork
      session(0);
      session(1);
      session(2);
      session(3);
    join
    step(4);
    for (int ch = 0; ch < N; ch++) begin
      check(cnt_of(ch) == exp_cnt(exp_press[ch]), "R8", "count per channel",
            int'(cnt_of(ch)), int'(exp_cnt(exp_press[ch])));
      check(pulse_cnt[ch] == exp_press[ch], "R6", "pulses per channel",
            pulse_cnt[ch], exp_press[ch]);
      check(level[ch] == 1'b0, "R3", "released after bounce", int'(level[ch]), 0);
    end
    check(wide_cnt == 0, "R4", "pulse width", wide_cnt, 0);

    // R5: wrap on channel 2 with other channels idle
    p0 = pulse_cnt[0];
    for (int k = 0; k < (1 << CW) + 1; k++) press_cycle(2);
    check(cnt_of(2) == exp_cnt(exp_press[2]), "R5", "count wraps",
          int'(cnt_of(2)), int'(exp_cnt(exp_press[2])));
    check(pulse_cnt[0] == p0 && cnt_of(0) == exp_cnt(exp_press[0]), "R6",
          "idle channel untouched", int'(cnt_of(0)), int'(exp_cnt(exp_press[0])));

    // R7: reset in the middle of a held press
    raw[3] = 1'b1;
    step(HOLD);
    check(level[3] == 1'b1, "R8", "held press accepted", int'(level[3]), 1);
    rst_n = 1'b0;
    step(2);
    check(level == '0, "R7", "level cleared by reset", int'(level), 0);
    check(count == '0, "R7", "counts cleared by reset", int'(count), 0);
    raw[3] = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
    measure(3, 1'b1, lat);
    check(lat >= LAT_MIN && lat <= LAT_MAX, "R7", "latency after reset", lat, LAT_MIN);
    step(2);
    check(cnt_of(3) == 1, "R7", "count after reset and press", int'(cnt_of(3)), 1);
    raw[3] = 1'b0;
    step(HOLD);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule